// File: doc/BRIEF.md
# Crypto Command Handshake Front-End

This block is the host-side entry point of a coprocessor that runs either elliptic-curve or block-cipher work. The host raises a start strobe together with a 1-bit mode and a 2-bit operation code. The block turns these into one of seven commands and reports that command to the engine as a one-hot vector. It then moves 32-bit words in both directions using a ready/done/acknowledge handshake. The real arithmetic engines are not part of this block. A stub stands in for them: it stays busy for a fixed, parameterised number of cycles, and its result words are formed from the XOR of all the words that were loaded.

A value that is one field element wide travels as six words. A cipher block travels as four words. Word index 0 is always the most significant word. The reserved code is rejected at the door and never reaches the engine.

Top module: `cop_host_front`

## Requirements
- R1: While an operation is in flight, `eng_cmd` has exactly one bit set, at index mode*4+oper. The mapping is: mode 0 with codes 0..3 gives standard-curve scalar multiply, custom-curve scalar multiply, standard-curve point add and custom-curve point add; mode 1 with codes 0..2 gives key expansion, encrypt and decrypt. In idle, `eng_cmd` is zero.
- R2: After reset the block is idle, and `word_ready`, `op_done`, `err_flag`, `eng_cmd` and `out_word` are all zero.
- R3: A start in idle with mode 1 and oper 3 leaves the block idle with `eng_cmd` zero, and `err_flag` reads 1 from the next cycle on. The next accepted valid start clears `err_flag`.
- R4: Mode and oper are captured only by a start seen in idle. Later changes to them, and further starts before the operation returns to idle, have no effect.
- R5: While loading, `word_ready` is 1 and every cycle with `host_ack` high accepts `in_word`. The number of input words is fixed per command (F = 6, B = 4): standard scalar 2F, custom scalar 3F, standard add 4F, custom add 5F, and B for each of the three cipher commands.
- R6: After the last input word is accepted, `word_ready` and `op_done` stay low for exactly BUSY_CYC cycles.
- R7: For commands with results, `op_done` is then held high and `out_word` shows result word j, starting at j = 0. Its value is X ^ j ^ (cmd << 16), where X is the XOR of all input words and cmd is mode*4+oper. Each cycle with `host_ack` high moves to the next word. Output counts are 2F for the curve commands and B for encrypt and decrypt. The cycle after the last word is acknowledged, the block is idle.
- R8: Key expansion has no output words. Once the busy time ends, `op_done` and `word_ready` are both high for exactly one cycle, and then the block is idle.
- R9: `host_ack` has no effect while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches an operation when the block is idle |
| mode | input | 1 | 0 selects elliptic-curve work, 1 selects block-cipher work |
| oper | input | 2 | Operation code within the selected mode |
| in_word | input | 32 | Input data word |
| host_ack | input | 1 | Host strobe: a word is presented while loading, or a word was taken while emitting |
| word_ready | output | 1 | The block can take an input word |
| op_done | output | 1 | The operation has finished and results are available |
| out_word | output | 32 | Current result word |
| eng_cmd | output | 7 | One-hot command sent to the engine |
| err_flag | output | 1 | The last start carried the reserved code |

## Verification
Every output comes from a register. A start or an acknowledge that is sampled at one rising edge therefore shows up in the state seen just after that edge. The bench drives and samples at falling edges, so each response is checked on the falling edge that directly follows the edge that caused it. The busy window is measured by counting falling edges with `op_done` low after the last accepted word, and that count must equal BUSY_CYC exactly. Each result word is compared while its acknowledge is pending. One word is also held for an extra cycle to show that it stays put until acknowledged.

// File: rtl/cop_front_pkg.sv
package cop_front_pkg;

    typedef enum logic [2:0] {
        CMD_SP_STD = 3'd0,
        CMD_SP_CUS = 3'd1,
        CMD_PA_STD = 3'd2,
        CMD_PA_CUS = 3'd3,
        CMD_KEYX   = 3'd4,
        CMD_ENC    = 3'd5,
        CMD_DEC    = 3'd6,
        CMD_RSV    = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_RUN,
        ST_EMIT,
        ST_FIN
    } fsm_e;

    localparam int unsigned N_CMD = 7;

    function automatic cmd_e to_cmd(input logic md, input logic [1:0] op);
        return cmd_e'({md, op});
    endfunction

    // Input word count per command; fw = words per field element, bw = words per block
    function automatic int unsigned in_words(input cmd_e c, input int unsigned fw,
                                             input int unsigned bw);
        case (c)
            CMD_SP_STD: return 2 * fw;
            CMD_SP_CUS: return 3 * fw;
            CMD_PA_STD: return 4 * fw;
            CMD_PA_CUS: return 5 * fw;
            default:    return bw;
        endcase
    endfunction

    function automatic int unsigned out_words(input cmd_e c, input int unsigned fw,
                                              input int unsigned bw);
        case (c)
            CMD_KEYX:        return 0;
            CMD_ENC, CMD_DEC: return bw;
            default:         return 2 * fw;
        endcase
    endfunction

endpackage

// File: rtl/cop_cmd_decode.sv
module cop_cmd_decode
    import cop_front_pkg::*;
(
    input  logic             mode,
    input  logic [1:0]       oper,
    output cmd_e             cmd,
    output logic             reserved,
    output logic [N_CMD-1:0] onehot
);
    assign cmd      = to_cmd(mode, oper);
    assign reserved = (cmd == CMD_RSV);

    for (genvar g = 0; g < N_CMD; g++) begin : g_bit
        assign onehot[g] = ({mode, oper} == 3'(g));
    end
endmodule

// File: rtl/cop_engine_stub.sv
module cop_engine_stub
    import cop_front_pkg::*;
#(
    parameter int unsigned BUSY_CYC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [N_CMD-1:0] cmd,
    output logic             finish
);
    localparam int unsigned BW = $clog2(BUSY_CYC + 1);

    logic          active;
    logic [BW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (go && |cmd) begin
            active <= 1'b1;
            cnt    <= BW'(BUSY_CYC - 1);
        end else if (finish) begin
            active <= 1'b0;
        end else if (active) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign finish = active && (cnt == '0);

    AST_STUB_NO_REGO: assert property (@(posedge clk) disable iff (rst)
        go |-> !active); // R6
endmodule

// File: rtl/cop_host_front.sv
module cop_host_front
    import cop_front_pkg::*;
#(
    parameter int unsigned WORD_W      = 32,
    parameter int unsigned FIELD_WORDS = 6,
    parameter int unsigned BLOCK_WORDS = 4,
    parameter int unsigned BUSY_CYC    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              mode,
    input  logic [1:0]        oper,
    input  logic [WORD_W-1:0] in_word,
    input  logic              host_ack,
    output logic              word_ready,
    output logic              op_done,
    output logic [WORD_W-1:0] out_word,
    output logic [N_CMD-1:0]  eng_cmd,
    output logic              err_flag
);
    localparam int unsigned MAX_WORDS = 5 * FIELD_WORDS;
    localparam int unsigned CNT_W     = $clog2(MAX_WORDS + 1);

    fsm_e              state;
    cmd_e              cmd_q;
    cmd_e              dec_cmd;
    logic              dec_rsv;
    logic [N_CMD-1:0]  dec_oh;
    logic [N_CMD-1:0]  oh_q;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  need_in;
    logic [CNT_W-1:0]  need_out;
    logic [WORD_W-1:0] acc;
    logic              err_q;
    logic              last_in;
    logic              go;
    logic              eng_finish;

    cop_cmd_decode u_dec (
        .mode     (mode),
        .oper     (oper),
        .cmd      (dec_cmd),
        .reserved (dec_rsv),
        .onehot   (dec_oh)
    );

    cop_engine_stub #(.BUSY_CYC(BUSY_CYC)) u_eng (
        .clk    (clk),
        .rst    (rst),
        .go     (go),
        .cmd    (oh_q),
        .finish (eng_finish)
    );

    assign need_in  = CNT_W'(in_words(cmd_q, FIELD_WORDS, BLOCK_WORDS));
    assign need_out = CNT_W'(out_words(cmd_q, FIELD_WORDS, BLOCK_WORDS));
    assign last_in  = (cnt == need_in - 1'b1);
    assign go       = (state == ST_LOAD) && host_ack && last_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cmd_q <= CMD_SP_STD;
            oh_q  <= '0;
            cnt   <= '0;
            acc   <= '0;
            err_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (dec_rsv) begin
                            err_q <= 1'b1;
                        end else begin
                            err_q <= 1'b0;
                            cmd_q <= dec_cmd;
                            oh_q  <= dec_oh;
                            acc   <= '0;
                            cnt   <= '0;
                            state <= ST_LOAD;
                        end
                    end
                end
                ST_LOAD: begin
                    if (host_ack) begin
                        acc <= acc ^ in_word;
                        if (last_in) begin
                            cnt   <= '0;
                            state <= ST_RUN;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_RUN: begin
                    if (eng_finish) begin
                        state <= (need_out == '0) ? ST_FIN : ST_EMIT;
                    end
                end
                ST_EMIT: begin
                    if (host_ack) begin
                        if (cnt == need_out - 1'b1) begin
                            cnt   <= '0;
                            oh_q  <= '0;
                            state <= ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_FIN: begin
                    oh_q  <= '0;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign word_ready = (state == ST_LOAD) || (state == ST_FIN);
    assign op_done    = (state == ST_EMIT) || (state == ST_FIN);
    assign out_word   = (state == ST_EMIT)
                      ? (acc ^ WORD_W'(cnt) ^ (WORD_W'(cmd_q) << 16)) : '0;
    assign eng_cmd    = oh_q;
    assign err_flag   = err_q;

    AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(eng_cmd)); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (!word_ready && !op_done && eng_cmd == '0)); // R2
    AST_RSV_REJECT: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start && mode && oper == 2'b11)
        |=> (state == ST_IDLE && err_flag && eng_cmd == '0)); // R3
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(eng_cmd)); // R4
    AST_IN_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD) |-> (cnt < need_in)); // R5
    AST_FIN_ONE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FIN) |=> (state == ST_IDLE)); // R8
endmodule

// File: tb/cop_host_front_bench.sv
module cop_host_front_bench;
    localparam int unsigned BUSY = 5;
    localparam int unsigned FW   = 6;
    localparam int unsigned BWD  = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        mode = 1'b0;
    logic [1:0]  oper = 2'b00;
    logic [31:0] in_word = '0;
    logic        host_ack = 1'b0;
    logic        word_ready, op_done, err_flag;
    logic [31:0] out_word;
    logic [6:0]  eng_cmd;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cop_host_front #(.WORD_W(32), .FIELD_WORDS(FW), .BLOCK_WORDS(BWD),
                     .BUSY_CYC(BUSY)) u_cop_host_front (
        .clk(clk), .rst(rst), .start(start), .mode(mode), .oper(oper),
        .in_word(in_word), .host_ack(host_ack), .word_ready(word_ready),
        .op_done(op_done), .out_word(out_word), .eng_cmd(eng_cmd),
        .err_flag(err_flag)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int n_in(input int c);
        case (c)
            0: return 2 * FW;
            1: return 3 * FW;
            2: return 4 * FW;
            3: return 5 * FW;
            default: return BWD;
        endcase
    endfunction

    function automatic int n_out(input int c);
        if (c == 4) return 0;
        if (c >= 5) return BWD;
        return 2 * FW;
    endfunction

    task automatic run_cmd(input int c, input int t);
        logic [31:0] acc;
        logic [31:0] w;
        logic [31:0] exp;
        int k;
        acc = '0;
        @(negedge clk);
        start = 1'b1; mode = c[2]; oper = c[1:0];
        @(negedge clk);
        start = 1'b0; mode = ~mode; oper = ~oper;   // R4: later changes ignored
        chk(word_ready == 1'b1, "R5", "ready after start", word_ready, 1);
        chk(eng_cmd == 7'(1 << c), "R1", "one-hot command", eng_cmd, 1 << c);
        chk(err_flag == 1'b0, "R3", "error cleared by valid start", err_flag, 0);
        for (int i = 0; i < n_in(c); i++) begin
            chk(word_ready == 1'b1 && op_done == 1'b0, "R5", "ready while loading",
                word_ready, 1);
            w = (32'h9E3779B9 * 32'(t + 1)) ^ (32'(i) * 32'h01010101) ^ (32'(c) << 24);
            acc = acc ^ w;
            in_word = w; host_ack = 1'b1;
            start = (i == 1);   // R4: start during operation ignored
            @(negedge clk);
            start = 1'b0;
            chk(eng_cmd == 7'(1 << c), "R4", "command held", eng_cmd, 1 << c);
        end
        host_ack = 1'b0;
        k = 0;
        while (!op_done && k < 100) begin
            chk(word_ready == 1'b0, "R6", "not ready while busy", word_ready, 0);
            k++;
            @(negedge clk);
        end
        chk(k == BUSY, "R6", "busy length", k, BUSY);
        if (n_out(c) == 0) begin
            chk(op_done && word_ready, "R8", "done with ready", {op_done, word_ready}, 3);
            @(negedge clk);
            chk(!op_done && !word_ready && eng_cmd == '0, "R8", "idle after one cycle",
                {op_done, word_ready}, 0);
        end else begin
            for (int j = 0; j < n_out(c); j++) begin
                exp = acc ^ 32'(j) ^ (32'(c) << 16);
                chk(op_done == 1'b1, "R7", "done while emitting", op_done, 1);
                chk(out_word == exp, "R7", "result word", out_word, exp);
                if (j == 0) begin
                    @(negedge clk);
                    chk(out_word == exp, "R7", "word held without ack", out_word, exp);
                end
                host_ack = 1'b1;
                @(negedge clk);
                host_ack = 1'b0;
            end
            chk(!op_done && eng_cmd == '0, "R7", "idle after last ack", op_done, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!word_ready && !op_done && !err_flag, "R2", "reset flags",
            {word_ready, op_done, err_flag}, 0);
        chk(eng_cmd == '0 && out_word == '0, "R2", "reset outputs", eng_cmd, 0);

        // R9: acknowledge in idle does nothing
        host_ack = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(!word_ready && !op_done && eng_cmd == '0, "R9", "ack in idle",
            {word_ready, op_done}, 0);
        host_ack = 1'b0;

        // R3: reserved code
        start = 1'b1; mode = 1'b1; oper = 2'b11;
        @(negedge clk);
        start = 1'b0;
        chk(err_flag == 1'b1, "R3", "reserved error flag", err_flag, 1);
        chk(!word_ready && eng_cmd == '0, "R3", "reserved stays idle", eng_cmd, 0);
        @(negedge clk);
        chk(err_flag == 1'b1 && !word_ready, "R3", "error held in idle", err_flag, 1);

        for (int t = 0; t < 2; t++) begin
            for (int c = 0; c < 7; c++) begin
                run_cmd(c, t);
            end
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int cyc = 0; cyc < 100000; cyc++) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule